// File: doc/BRIEF.md
# Ternary Prefix-Code Lookup Table

This block turns the head of a left-aligned, variable-length coded stream into a decoded symbol. Each entry holds an 8-bit pattern, an 8-bit care mask and a 20-bit result word. A mask bit of 0 makes that key bit a wildcard, so one entry covers a prefix code of any length from 1 to 8 bits, whatever stream bits follow it. A hit returns the 16-bit decoded half-instruction and the code length. The surrounding decoder feeds that length to its realignment shifter so the next code starts at the key's most significant bit.

The table is filled through a write port while the decoder's table-load mode is active. The decoder can use two instances side by side, one per 16-bit half of an instruction. A lookup is presented for one cycle, and its registered result appears on the next cycle. When several entries match, the valid entry with the lowest index wins. The entry at the highest index is reserved as the escape, which tells the decoder that the next 16 raw stream bits follow uncoded. A key that matches no valid entry raises a miss flag.

Top module: `tern_prefix_lut`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss until an entry is written.
- R2: A write (`wr_en`=1) stores pattern, mask and result at `wr_idx` and makes that entry valid only when `load_mode`=1. A write with `load_mode`=0 leaves the table unchanged.
- R3: A valid entry matches a key when `((key ^ pattern) & mask) == 0`, where mask bit 1 means the bit is compared and 0 means don't care. Key bit 7 is the first stream bit.
- R4: When more than one valid entry matches, the result comes from the matching entry with the lowest index, and `rs_idx` reports that index.
- R5: On a hit, `rs_sym` equals result bits 19:4 and `rs_len` equals result bits 3:0 of the winning entry. Loaded entries carry a length from 1 to 8.
- R6: On a miss, `rs_miss`=1, `rs_hit`=0, and `rs_sym`, `rs_len`, `rs_idx` and `rs_esc` are all 0.
- R7: `rs_esc`=1 exactly when the winning entry is the reserved escape entry at index ENTRIES-1 (127 by default).
- R8: A lookup presented with `lk_valid`=1 on one rising edge yields `rs_valid`=1 with its result after that edge, for one cycle. `rs_valid` is 0 in any cycle that follows an edge without a lookup.
- R9: A lookup on the same edge as a write sees the table contents from before that write. A later write to an index replaces the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_mode | input | 1 | Table-load mode, enables writes |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 7 | Entry index to write |
| wr_pat | input | 8 | Pattern bits |
| wr_care | input | 8 | Care mask, 1 = compare |
| wr_res | input | 20 | Result word: symbol 19:4, length 3:0 |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 8 | Top 8 bits of the aligned stream |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A valid entry matched |
| rs_miss | output | 1 | No valid entry matched |
| rs_esc | output | 1 | Escape entry won |
| rs_idx | output | 7 | Winning entry index |
| rs_sym | output | 16 | Decoded symbol |
| rs_len | output | 4 | Code length in bits |

## Verification
The assertions assume that every write made in load mode carries a length field from 1 to 8, and one assertion flags any write that breaks this. They also assume that the mask of each entry matches its code length, but the RTL does not check that. The stimulus keeps to both assumptions. It writes prefix-shaped masks with lengths in range, and it writes with a zero mask only for wildcard entries whose length is set explicitly. The bench keeps its own copy of the table, updated only by writes made in load mode. It searches that copy in index order to predict each result, so overlapping entries, same-edge write and lookup, and writes with load mode off are all predicted without reference to the RTL.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
  localparam int KEY_W = 8;
  localparam int SYM_W = 16;
  localparam int LEN_W = 4;
  localparam int RES_W = SYM_W + LEN_W;

  typedef struct packed {
    logic [KEY_W-1:0] pat;
    logic [KEY_W-1:0] care;
    logic [RES_W-1:0] res;
  } tpl_entry_t;
endpackage

// File: rtl/tpl_entry_store.sv
module tpl_entry_store
  import tpl_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_mode,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  tpl_entry_t         wr_ent,
  input  logic [KEY_W-1:0]   key,
  input  logic [IDX_W-1:0]   sel_idx,
  output logic [ENTRIES-1:0] match_vec,
  output logic [RES_W-1:0]   sel_res
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] wr_sel;
  tpl_entry_t         ent_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_sel[g] = wr_en & load_mode & (wr_idx == IDX_W'(g));

    always_comb begin
      valid_d[g] = valid_q[g] | wr_sel[g];
    end

    always_ff @(posedge clk) begin
      if (wr_sel[g]) ent_q[g] <= wr_ent;
    end

    assign match_vec[g] = valid_q[g] &
                          (((key ^ ent_q[g].pat) & ent_q[g].care) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign sel_res = ent_q[sel_idx].res;

  // R2
  wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load_mode) |=> $stable(valid_q));

  // R2
  wr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && load_mode) |=> valid_q[$past(wr_idx)]);

  // R5
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && load_mode) |->
      (wr_ent.res[LEN_W-1:0] >= LEN_W'(1) && wr_ent.res[LEN_W-1:0] <= LEN_W'(KEY_W)));
endmodule

// File: rtl/tpl_prio_pick.sv
module tpl_prio_pick #(
  parameter int N = 128,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R4
  always_comb begin
    prio_lowest_chk: assert (!any || (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));
  end
endmodule

// File: rtl/tpl_result_reg.sv
module tpl_result_reg
  import tpl_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ESC_IDX = ENTRIES - 1,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [RES_W-1:0] res,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic             rs_miss,
  output logic             rs_esc,
  output logic [IDX_W-1:0] rs_idx,
  output logic [SYM_W-1:0] rs_sym,
  output logic [LEN_W-1:0] rs_len
);
  logic             v_d, h_d, m_d, e_d;
  logic [IDX_W-1:0] i_d;
  logic [SYM_W-1:0] s_d;
  logic [LEN_W-1:0] l_d;

  always_comb begin
    v_d = lk_valid;
    h_d = lk_valid & hit;
    m_d = lk_valid & ~hit;
    e_d = h_d & (idx == IDX_W'(ESC_IDX));
    i_d = h_d ? idx : '0;
    s_d = h_d ? res[RES_W-1:LEN_W] : '0;
    l_d = h_d ? res[LEN_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_esc   <= 1'b0;
      rs_idx   <= '0;
      rs_sym   <= '0;
      rs_len   <= '0;
    end else begin
      rs_valid <= v_d;
      rs_hit   <= h_d;
      rs_miss  <= m_d;
      rs_esc   <= e_d;
      rs_idx   <= i_d;
      rs_sym   <= s_d;
      rs_len   <= l_d;
    end
  end

  // R8
  rs_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);

  // R8
  rs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

  // R7
  esc_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_esc |-> (rs_hit && rs_idx == IDX_W'(ESC_IDX)));

  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_miss |-> (!rs_hit && !rs_esc && rs_sym == '0 && rs_len == '0 && rs_idx == '0));
endmodule

// File: rtl/tern_prefix_lut.sv
module tern_prefix_lut
  import tpl_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ESC_IDX = ENTRIES - 1,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_mode,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_pat,
  input  logic [KEY_W-1:0] wr_care,
  input  logic [RES_W-1:0] wr_res,
  input  logic             lk_valid,
  input  logic [KEY_W-1:0] lk_key,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic             rs_miss,
  output logic             rs_esc,
  output logic [IDX_W-1:0] rs_idx,
  output logic [SYM_W-1:0] rs_sym,
  output logic [LEN_W-1:0] rs_len
);
  tpl_entry_t         wr_ent;
  logic [ENTRIES-1:0] match_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;
  logic [RES_W-1:0]   win_res;

  assign wr_ent = '{pat: wr_pat, care: wr_care, res: wr_res};

  tpl_entry_store #(.ENTRIES(ENTRIES)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_mode (load_mode),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_ent    (wr_ent),
    .key       (lk_key),
    .sel_idx   (win_idx),
    .match_vec (match_vec),
    .sel_res   (win_res)
  );

  tpl_prio_pick #(.N(ENTRIES)) i_pick (
    .req (match_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  tpl_result_reg #(.ENTRIES(ENTRIES), .ESC_IDX(ESC_IDX)) i_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .hit      (any_hit),
    .idx      (win_idx),
    .res      (win_res),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_miss  (rs_miss),
    .rs_esc   (rs_esc),
    .rs_idx   (rs_idx),
    .rs_sym   (rs_sym),
    .rs_len   (rs_len)
  );

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && lk_valid) |=> rs_miss);
endmodule

// File: tb/test_tern_prefix_lut.sv
module test_tern_prefix_lut;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_mode, wr_en, lk_valid;
  logic [6:0]  wr_idx;
  logic [7:0]  wr_pat, wr_care, lk_key;
  logic [19:0] wr_res;
  logic        rs_valid, rs_hit, rs_miss, rs_esc;
  logic [6:0]  rs_idx;
  logic [15:0] rs_sym;
  logic [3:0]  rs_len;

  always #5 clk = ~clk;

  tern_prefix_lut i_tern_prefix_lut (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_pat(wr_pat), .wr_care(wr_care), .wr_res(wr_res),
    .lk_valid(lk_valid), .lk_key(lk_key), .rs_valid(rs_valid),
    .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_esc(rs_esc), .rs_idx(rs_idx),
    .rs_sym(rs_sym), .rs_len(rs_len)
  );

  typedef struct {
    bit          hit;
    bit          esc;
    logic [6:0]  idx;
    logic [15:0] sym;
    logic [3:0]  len;
    string       req;
  } exp_t;

  exp_t        sb[$];
  bit          m_val [128];
  logic [7:0]  m_pat [128];
  logic [7:0]  m_care[128];
  logic [19:0] m_res [128];
  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;

  function automatic exp_t predict(logic [7:0] key, string req);
    exp_t e;
    e.hit = 0; e.esc = 0; e.idx = '0; e.sym = '0; e.len = '0; e.req = req;
    for (int i = 0; i < 128; i++) begin
      if (!e.hit && m_val[i] && (((key ^ m_pat[i]) & m_care[i]) == 8'h00)) begin
        e.hit = 1;
        e.idx = 7'(i);
        e.sym = m_res[i][19:4];
        e.len = m_res[i][3:0];
        e.esc = (i == 127);
      end
    end
    return e;
  endfunction

  task automatic step(bit we, int idx, logic [7:0] pat, logic [7:0] care,
                      logic [19:0] res, bit lv, logic [7:0] key, string req);
    @(negedge clk);
    wr_en = we; wr_idx = 7'(idx); wr_pat = pat; wr_care = care; wr_res = res;
    lk_valid = lv; lk_key = key;
    if (lv) sb.push_back(predict(key, req));
    if (we && load_mode) begin
      m_val[idx] = 1; m_pat[idx] = pat; m_care[idx] = care; m_res[idx] = res;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; lk_valid = 0;
  endtask

  task automatic look(logic [7:0] key, string req);
    step(0, 0, 8'h00, 8'h00, 20'h0, 1, key, req);
  endtask

  task automatic put(int idx, logic [7:0] pat, logic [7:0] care, logic [19:0] res);
    step(1, idx, pat, care, res, 0, 8'h00, "");
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rs_valid === 1'b1) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R8: rs_valid=1 with no lookup pending, expected rs_valid=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rs_hit !== e.hit || rs_miss !== !e.hit || rs_esc !== e.esc ||
            rs_idx !== e.idx || rs_sym !== e.sym || rs_len !== e.len) begin
          fails++;
          $display("FAIL %s: got hit=%0b miss=%0b esc=%0b idx=%0d sym=%h len=%0d, expected hit=%0b miss=%0b esc=%0b idx=%0d sym=%h len=%0d",
                   e.req, rs_hit, rs_miss, rs_esc, rs_idx, rs_sym, rs_len,
                   e.hit, !e.hit, e.esc, e.idx, e.sym, e.len);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, got cycle %0d, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) m_val[i] = 0;
    rst_n = 0; load_mode = 0; wr_en = 0; lk_valid = 0;
    wr_idx = '0; wr_pat = '0; wr_care = '0; wr_res = '0; lk_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (rs_valid !== 0 || rs_hit !== 0 || rs_miss !== 0 || rs_esc !== 0 ||
        rs_sym !== 0 || rs_len !== 0 || rs_idx !== 0) begin
      fails++;
      $display("FAIL R1: outputs after reset valid=%0b hit=%0b sym=%h, expected all 0",
               rs_valid, rs_hit, rs_sym);
    end
    // R1: empty table misses
    look(8'h00, "R1");
    look(8'hFF, "R1");
    // R2: writes with load_mode off are ignored
    put(0, 8'h00, 8'h00, {16'hDEAD, 4'd1});
    idle();
    look(8'h5A, "R2");
    // load entries
    load_mode = 1;
    put(5, 8'b1010_0000, 8'b1110_0000, {16'hA5A5, 4'd3});
    put(2, 8'b1000_0000, 8'b1100_0000, {16'h1234, 4'd2});
    put(60, 8'b0110_1001, 8'hFF, {16'hBEEF, 4'd8});
    put(127, 8'b0000_0000, 8'b1111_0000, {16'h0000, 4'd4});
    idle();
    // R3: ternary match, short code with trailing wildcards
    look(8'b1011_1111, "R3");
    look(8'b1110_0000, "R3");
    // R4: both idx 2 and idx 5 match key 1010_0101
    look(8'hA5, "R4");
    // R5: full 8-bit code
    look(8'h69, "R5");
    look(8'h68, "R6");
    // R7: escape entry
    look(8'h0C, "R7");
    // R8: back-to-back lookups
    look(8'h80, "R8");
    look(8'h81, "R8");
    idle();
    idle();
    // R9: same-edge write and lookup sees old contents
    step(1, 1, 8'h00, 8'h00, {16'h7777, 4'd5}, 1, 8'hFF, "R9");
    look(8'hFF, "R9");
    put(1, 8'hC0, 8'hC0, {16'h4321, 4'd2});
    look(8'hFF, "R9");
    look(8'h3F, "R6");
    // R2 again: write with load_mode off does not replace idx 1
    load_mode = 0;
    put(1, 8'h00, 8'h00, {16'h9999, 4'd1});
    look(8'h3F, "R2");
    look(8'hC3, "R2");
    idle(); idle(); idle();
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R8: %0d results missing, expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule